// File: doc/BRIEF.md
# Top-Region Write Protection Qualifier

This block sits between a write source and an 8K-byte nonvolatile data array. It judges each array write request against a 3-bit protection selector kept in its own status field. The selector names a region that always ends at the top address and grows downward. Writes that land inside that region are refused. While the supply is reported as unstable (ramping up or down), every write is refused.

The selector covers two kinds of region. Three settings are fractional: a quarter, a half or all of the array. Four settings are small fixed sizes from 64 to 512 bytes. One setting protects nothing. The selector itself can only be rewritten while the hardware write-protect pin is low and the supply is good. Its value stays readable at all times.

Each request is qualified one clock later. The result is either a one-cycle enable pulse for the array or status write, or a one-cycle refusal pulse.

Top module: `wp_guard`

## Requirements
- R1: During and right after reset, `memWrEn`, `statWrEn` and `wrBlocked` are 0 and `protField` reads 000.
- R2: With `protField` = 000, an array write to any address, including 0000h and 1FFFh, is granted.
- R3: Codes 001, 010 and 011 protect from 1800h, 1000h and 0000h respectively, up to 1FFFh. A write one below the lower bound is granted and a write at the bound is refused.
- R4: Codes 100, 101, 110 and 111 protect the top 64, 128, 256 and 512 bytes, with lower bounds 1FC0h, 1F80h, 1F00h and 1E00h. The bound address is refused and the address one below it is granted.
- R5: A granted array write request sampled at one clock edge gives `memWrEn` high for exactly the following cycle.
- R6: A refused request gives no enable and gives `wrBlocked` high for exactly the following cycle.
- R7: While `powerGood` is 0, array and status writes are all refused and `protField` keeps its value.
- R8: While `wpPin` is 1, a status write is refused, `protField` is unchanged and stays readable.
- R9: With `wpPin` 0 and `powerGood` 1, a status write loads `statWrData` into `protField` at the same edge that raises `statWrEn` for one cycle.
- R10: `wpPin` has no effect on whether an array write is granted.
- R11: `protField` changes only through a granted status write.
- R12: Without any request, all three qualifier outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| memWrReq | input | 1 | Array write request, one cycle |
| memWrAddr | input | 13 | Byte address of the array write |
| statWrReq | input | 1 | Status selector write request, one cycle |
| statWrData | input | 3 | New protection selector value |
| wpPin | input | 1 | Hardware write-protect for the selector |
| powerGood | input | 1 | High when the supply is stable |
| memWrEn | output | 1 | Array write permitted (one-cycle pulse) |
| statWrEn | output | 1 | Selector write performed (one-cycle pulse) |
| wrBlocked | output | 1 | A request was refused (one-cycle pulse) |
| protField | output | 3 | Current protection selector |

## Verification
Some rules are checked by assertions on every cycle:
- no enable follows an unpowered cycle;
- no array enable follows an address that the comparator placed in the region;
- no selector write follows a high protect pin;
- the selector never changes without a status write enable;
- every refusal pulse traces back to a request.

Only the bench scenarios can show the other rules:
- that each code yields the exact lower bound, with the boundary addresses on both sides tested for every setting;
- that the fractional and fixed encodings are not swapped;
- that the pin leaves array writes untouched.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    PROT_NONE    = 3'b000,
    PROT_QUARTER = 3'b001,
    PROT_HALF    = 3'b010,
    PROT_ALL     = 3'b011,
    PROT_TOP_S0  = 3'b100,
    PROT_TOP_S1  = 3'b101,
    PROT_TOP_S2  = 3'b110,
    PROT_TOP_S3  = 3'b111
  } protSel_t;

  typedef struct packed {
    logic memGrant;
    logic statGrant;
    logic blocked;
  } wpStrobe_t;

endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
(
  input  logic      memWrReq,
  input  logic      statWrReq,
  input  logic      wpPin,
  input  logic      powerGood,
  input  logic      inRegion,
  output wpStrobe_t strobe
);

  logic memOk;
  logic statOk;

  always_comb begin
    // array writes depend on supply and region only; the pin guards the selector
    memOk  = powerGood && !inRegion;
    statOk = powerGood && !wpPin;
    strobe.memGrant  = memWrReq && memOk;
    strobe.statGrant = statWrReq && statOk;
    strobe.blocked   = (memWrReq && !memOk) || (statWrReq && !statOk);
  end

endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SMALL_LOG2  = 6,
  parameter logic [FIELD_W-1:0] RESET_FIELD = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] newField,
  input  wpStrobe_t          strobe,
  output logic               inRegion,
  output logic               memWrEn,
  output logic               statWrEn,
  output logic               wrBlocked,
  output logic [FIELD_W-1:0] protField
);

  localparam int SZ_W = ADDR_W + 1;
  localparam logic [SZ_W-1:0] FULL_SZ  = SZ_W'(1) << ADDR_W;
  localparam logic [SZ_W-1:0] HALF_SZ  = FULL_SZ >> 1;
  localparam logic [SZ_W-1:0] QUART_SZ = FULL_SZ >> 2;
  localparam logic [SZ_W-1:0] SMALL_SZ = SZ_W'(1) << SMALL_LOG2;

  protSel_t        fieldQ;
  logic [SZ_W-1:0] regionSize;
  logic [SZ_W-1:0] regionBase;

  // region size from selector; fixed sizes double per step above the smallest
  always_comb begin
    unique case (fieldQ)
      PROT_NONE:    regionSize = '0;
      PROT_QUARTER: regionSize = QUART_SZ;
      PROT_HALF:    regionSize = HALF_SZ;
      PROT_ALL:     regionSize = FULL_SZ;
      default:      regionSize = SMALL_SZ << fieldQ[1:0];
    endcase
    regionBase = FULL_SZ - regionSize;
    inRegion   = (regionSize != '0) && ({1'b0, addr} >= regionBase);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fieldQ    <= protSel_t'(RESET_FIELD);
      memWrEn   <= 1'b0;
      statWrEn  <= 1'b0;
      wrBlocked <= 1'b0;
    end else begin
      memWrEn   <= strobe.memGrant;
      statWrEn  <= strobe.statGrant;
      wrBlocked <= strobe.blocked;
      if (strobe.statGrant) begin
        fieldQ <= protSel_t'(newField);
      end
    end
  end

  assign protField = fieldQ;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int SMALL_LOG2 = 6,
  parameter logic [FIELD_W-1:0] RESET_FIELD = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               memWrReq,
  input  logic [ADDR_W-1:0]  memWrAddr,
  input  logic               statWrReq,
  input  logic [FIELD_W-1:0] statWrData,
  input  logic               wpPin,
  input  logic               powerGood,
  output logic               memWrEn,
  output logic               statWrEn,
  output logic               wrBlocked,
  output logic [FIELD_W-1:0] protField
);

  wpStrobe_t strobe;
  logic      inRegion;

  wp_ctrl i_ctrl (
    .memWrReq  (memWrReq),
    .statWrReq (statWrReq),
    .wpPin     (wpPin),
    .powerGood (powerGood),
    .inRegion  (inRegion),
    .strobe    (strobe)
  );

  wp_datapath #(
    .ADDR_W      (ADDR_W),
    .SMALL_LOG2  (SMALL_LOG2),
    .RESET_FIELD (RESET_FIELD)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (memWrAddr),
    .newField  (statWrData),
    .strobe    (strobe),
    .inRegion  (inRegion),
    .memWrEn   (memWrEn),
    .statWrEn  (statWrEn),
    .wrBlocked (wrBlocked),
    .protField (protField)
  );

  AST_UNPOWERED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(powerGood) |-> !memWrEn && !statWrEn); // R7
  AST_REGION_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> !$past(inRegion)); // R6
  AST_PIN_LOCKS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    statWrEn |-> !$past(wpPin)); // R8
  AST_FIELD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(protField) |-> statWrEn); // R11
  AST_BLOCK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wrBlocked |-> $past(memWrReq || statWrReq)); // R12
  AST_GRANT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> $past(memWrReq)); // R5

endmodule

// File: tb/test_wp_guard.sv
`timescale 1ns/1ps
module test_wp_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        memWrReq = 1'b0;
  logic [12:0] memWrAddr = '0;
  logic        statWrReq = 1'b0;
  logic [2:0]  statWrData = '0;
  logic        wpPin = 1'b0;
  logic        powerGood = 1'b0;
  logic        memWrEn, statWrEn, wrBlocked;
  logic [2:0]  protField;

  int checks = 0;
  int failures = 0;
  logic [2:0] modelField = 3'b000;

  typedef struct {
    logic       mem;
    logic       stat;
    logic       blk;
    logic [2:0] fld;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #2 clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rst_n(rst_n), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .statWrReq(statWrReq), .statWrData(statWrData), .wpPin(wpPin),
    .powerGood(powerGood), .memWrEn(memWrEn), .statWrEn(statWrEn),
    .wrBlocked(wrBlocked), .protField(protField)
  );

  function automatic logic modelInRegion(logic [2:0] f, logic [12:0] a);
    int sz;
    case (f)
      3'd1: sz = 2048;
      3'd2: sz = 4096;
      3'd3: sz = 8192;
      3'd4: sz = 64;
      3'd5: sz = 128;
      3'd6: sz = 256;
      3'd7: sz = 512;
      default: sz = 0;
    endcase
    return (sz != 0) && (int'(a) >= 8192 - sz);
  endfunction

  task automatic compare(expItem_t e);
    checks++;
    if (memWrEn !== e.mem || statWrEn !== e.stat || wrBlocked !== e.blk || protField !== e.fld) begin
      failures++;
      $display("FAIL %s actual mem=%b stat=%b blk=%b fld=%0d expected mem=%b stat=%b blk=%b fld=%0d",
               e.tag, memWrEn, statWrEn, wrBlocked, protField, e.mem, e.stat, e.blk, e.fld);
    end
  endtask

  // monitor: results appear after the edge that follows the request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() != 0) compare(scoreQ.pop_front());
    end
  end

  task automatic drive(input logic mReq, input logic [12:0] addr, input logic sReq,
                       input logic [2:0] data, input logic wp, input logic pg, input string tag);
    expItem_t e;
    expItem_t idle;
    logic eMem, eStat;
    @(negedge clk);
    memWrReq = mReq; memWrAddr = addr; statWrReq = sReq; statWrData = data;
    wpPin = wp; powerGood = pg;
    eMem  = mReq && pg && !modelInRegion(modelField, addr);
    eStat = sReq && pg && !wp;
    if (eStat) modelField = data;
    e.mem = eMem; e.stat = eStat; e.blk = (mReq && !eMem) || (sReq && !eStat);
    e.fld = modelField; e.tag = tag;
    scoreQ.push_back(e);
    @(negedge clk);
    memWrReq = 1'b0; statWrReq = 1'b0;
    idle.mem = 1'b0; idle.stat = 1'b0; idle.blk = 1'b0; idle.fld = modelField;
    idle.tag = {tag, " R12 idle after"};
    scoreQ.push_back(idle);
  endtask

  task automatic setField(input logic [2:0] f, input string tag);
    drive(1'b0, 13'h0, 1'b1, f, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(negedge clk);
    r.mem = 1'b0; r.stat = 1'b0; r.blk = 1'b0; r.fld = 3'b000; r.tag = "R1 in reset";
    compare(r);
    @(negedge clk);
    rst_n = 1'b1; powerGood = 1'b1;
    @(negedge clk);
    r.tag = "R1 after reset";
    compare(r);

    drive(1'b1, 13'h0000, 1'b0, 3'd0, 1'b0, 1'b1, "R2 field0 addr 0000");
    drive(1'b1, 13'h1FFF, 1'b0, 3'd0, 1'b0, 1'b1, "R2 R5 field0 addr 1FFF");
    drive(1'b0, 13'h0000, 1'b0, 3'd0, 1'b0, 1'b1, "R12 no request");

    setField(3'd1, "R9 load quarter");
    drive(1'b1, 13'h17FF, 1'b0, 3'd0, 1'b0, 1'b1, "R3 quarter below");
    drive(1'b1, 13'h1800, 1'b0, 3'd0, 1'b0, 1'b1, "R3 R6 quarter bound");
    setField(3'd2, "R9 load half");
    drive(1'b1, 13'h0FFF, 1'b0, 3'd0, 1'b0, 1'b1, "R3 half below");
    drive(1'b1, 13'h1000, 1'b0, 3'd0, 1'b0, 1'b1, "R3 half bound");
    setField(3'd3, "R9 load all");
    drive(1'b1, 13'h0000, 1'b0, 3'd0, 1'b0, 1'b1, "R3 all bottom");

    for (int c = 4; c < 8; c++) begin
      logic [12:0] bnd;
      bnd = 13'(8192 - (64 << (c - 4)));
      setField(3'(c), "R9 load fixed size");
      drive(1'b1, bnd - 13'd1, 1'b0, 3'd0, 1'b0, 1'b1, "R4 fixed below");
      drive(1'b1, bnd, 1'b0, 3'd0, 1'b0, 1'b1, "R4 fixed bound");
      drive(1'b1, 13'h1FFF, 1'b0, 3'd0, 1'b0, 1'b1, "R4 fixed top");
    end

    drive(1'b0, 13'h0, 1'b1, 3'd0, 1'b1, 1'b1, "R8 pin locks selector");
    drive(1'b1, 13'h1DFF, 1'b0, 3'd0, 1'b1, 1'b1, "R10 pin high write below");
    drive(1'b1, 13'h1E00, 1'b0, 3'd0, 1'b1, 1'b1, "R10 pin high write inside");
    setField(3'd0, "R9 clear selector");
    drive(1'b1, 13'h0100, 1'b0, 3'd0, 1'b0, 1'b0, "R7 unpowered array write");
    drive(1'b0, 13'h0, 1'b1, 3'd5, 1'b0, 1'b0, "R7 unpowered selector write");
    drive(1'b1, 13'h1FFF, 1'b1, 3'd3, 1'b0, 1'b1, "R9 R5 simultaneous writes");
    drive(1'b1, 13'h0000, 1'b1, 3'd6, 1'b1, 1'b1, "R8 R11 locked with array write");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule